// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache with Bus Snarfing

This block is a 64 KB data cache placed between a single processor port and a shared memory bus. Storage is split into two ways of 1024 sets each, with one 32-byte line per set per way. Every processor write is forwarded to memory (write-through). A read that misses fetches the whole line in eight word beats, lowest word first, and then returns the requested word. A write that misses does not pull the line into the cache.

A snoop port watches word writes that other bus masters place on the shared bus. When such a write falls inside a resident line, the cache copies the new word into that line, so the line stays valid and current instead of being thrown away. Writes that this cache forwarded itself also appear on the snoop port. They carry the cache's own source number and are ignored. A processor access that meets a snoop to the same set in the same cycle waits one cycle, and the snoop update lands first.

The controller has four states. IDLE accepts a request. FILL collects the refill beats. WRITE waits for the memory write acknowledge. RESP holds the one-cycle response. The transitions are:
- IDLE→RESP on a read hit.
- IDLE→FILL on a read miss.
- IDLE→WRITE on any write.
- IDLE→IDLE when there is no request or a same-set snoop stalls the request.
- FILL→RESP when the eighth beat is taken.
- WRITE→RESP on acknowledge.
- RESP→IDLE always.

Top module: `snarf_cache2w`

## Requirements
- R1: The byte address splits into tag = addr[31:15], set = addr[14:5] and word-in-line = addr[4:2]. There are 1024 sets, two ways per set, and 8 words of 32 bits per line.
- R2: After reset every line is invalid. cpu_ready, mem_rd_req and mem_wr_req are low, and the first read of any address misses.
- R3: A read is a hit when a valid way of the indexed set holds the request tag. A read hit raises cpu_ready with cpu_hit=1 and the word one cycle after acceptance, and at most one way ever matches.
- R4: A read miss raises mem_rd_req with the line-aligned address and takes eight beats, where beat k is word k. cpu_ready follows one cycle after the eighth beat, with cpu_hit=0 and the requested word. The line is then resident.
- R5: Every write is forwarded. mem_wr_req, mem_wr_addr and mem_wr_data are set the cycle after acceptance and held until mem_wr_ack. cpu_ready follows one cycle after the acknowledge, and cpu_hit tells whether the line was resident. A write hit also updates the cached word.
- R6: A write miss allocates nothing, and a later read of that address misses.
- R7: On a read miss, an invalid way is filled first, way 0 before way 1. Otherwise the least recently used way of the set is replaced. Processor hits and fills mark their way as most recently used.
- R8: A snoop write from another source (snp_src ≠ own source, default 0) to a resident line replaces that word in the cache and leaves the line valid. A later read hits with the snooped data.
- R9: A snoop write to a line that is not resident changes no cache state, and a later read of it misses.
- R10: A snoop write that carries the cache's own source number is ignored, and the cached word keeps its old value.
- R11: When an active snoop and a new processor request hit the same set in one cycle, the snoop is applied and the request is accepted one cycle later. A snoop to another set causes no delay.
- R12: cpu_ready is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Line was resident, valid with cpu_ready |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready for reads |
| mem_rd_req | output | 1 | Line refill request, held for the whole refill |
| mem_rd_addr | output | 32 | Line-aligned refill address |
| mem_rd_valid | input | 1 | Refill beat present |
| mem_rd_data | input | 32 | Refill beat word |
| mem_wr_req | output | 1 | Forwarded write request |
| mem_wr_addr | output | 32 | Forwarded write byte address |
| mem_wr_data | output | 32 | Forwarded write word |
| mem_wr_ack | input | 1 | Memory took the write |
| snp_valid | input | 1 | A word write is on the shared bus |
| snp_src | input | 2 | Source number of the bus writer |
| snp_waddr | input | 30 | Word address of the bus write |
| snp_data | input | 32 | Word written on the bus |

## Verification
Each result has a fixed due cycle, counted in rising edges from the edge that accepts the request:
- A read hit is due on the first edge after acceptance.
- A write completes two edges after acceptance when memory acknowledges at once.
- A read miss completes nine edges after acceptance when memory returns one beat per cycle.
- A same-set snoop adds exactly one edge.

The bench raises each request half a cycle before an edge, counts edges until it sees cpu_ready, and samples just after each edge. It compares that count with the latency its own residency model predicts, so a wrong hit or miss decision shows up as a timing miscompare as well as a data one. It also checks that cpu_ready is low one edge later.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_RESP
    } sc_state_e;
endpackage

// File: rtl/sc_way.sv
module sc_way #(
    parameter int SETS   = 1024,
    parameter int TAG_W  = 17,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(SETS)-1:0]    look_idx,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       look_hit,
    output logic                       look_vld,
    output logic [WORDS*DATA_W-1:0]    look_line,
    input  logic                       cpu_wr_en,
    input  logic [$clog2(WORDS)-1:0]   cpu_wsel,
    input  logic [DATA_W-1:0]          cpu_wdata,
    input  logic                       fill_en,
    input  logic [WORDS*DATA_W-1:0]    fill_line,
    input  logic                       snp_en,
    input  logic [$clog2(SETS)-1:0]    snp_idx,
    input  logic [TAG_W-1:0]           snp_tag,
    input  logic [$clog2(WORDS)-1:0]   snp_wsel,
    input  logic [DATA_W-1:0]          snp_data
);
    localparam int LINE_W = WORDS * DATA_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];
    logic              snp_match;

    assign look_vld  = valid_q[look_idx];
    assign look_hit  = look_vld && (tag_q[look_idx] == look_tag);
    assign look_line = data_q[look_idx];
    assign snp_match = snp_en && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[look_idx] <= 1'b1;
        end
    end

    // order matters: snoop first, then processor word, then whole-line fill
    always_ff @(posedge clk) begin
        if (snp_match) begin
            data_q[snp_idx][snp_wsel*DATA_W +: DATA_W] <= snp_data;
        end
        if (cpu_wr_en) begin
            data_q[look_idx][cpu_wsel*DATA_W +: DATA_W] <= cpu_wdata;
        end
        if (fill_en) begin
            data_q[look_idx] <= fill_line;
            tag_q[look_idx]  <= look_tag;
        end
    end

    // R8
    snoop_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_match && !(fill_en && look_idx == snp_idx)) |=> valid_q[$past(snp_idx)]);
endmodule

// File: rtl/sc_lru.sv
module sc_lru #(
    parameter int SETS = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_idx,
    output logic                    victim,
    input  logic                    we,
    input  logic [$clog2(SETS)-1:0] wr_idx,
    input  logic                    wr_way
);
    logic [SETS-1:0] lru_q;

    assign victim = lru_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (we) begin
            lru_q[wr_idx] <= ~wr_way;
        end
    end

    // R7
    lru_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (lru_q[$past(wr_idx)] == !$past(wr_way)));
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic                         cpu_ready,
    output logic                         cpu_hit,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic [IDX_W-1:0]             cur_idx,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] cur_tag,
    output logic [$clog2(WORDS)-1:0]     cur_wsel,
    input  logic [1:0]                   look_hit,
    input  logic [1:0]                   look_vld,
    input  logic [DATA_W-1:0]            hit_word,
    input  logic                         lru_victim,
    input  logic                         snp_conflict,
    output logic [1:0]                   cpu_wr_en,
    output logic [1:0]                   fill_en,
    output logic [WORDS*DATA_W-1:0]      fill_line,
    output logic                         lru_we,
    output logic                         lru_way,
    output logic                         mem_rd_req,
    output logic [ADDR_W-1:0]            mem_rd_addr,
    input  logic                         mem_rd_valid,
    input  logic [DATA_W-1:0]            mem_rd_data,
    output logic                         mem_wr_req,
    output logic [ADDR_W-1:0]            mem_wr_addr,
    output logic [DATA_W-1:0]            mem_wr_data,
    input  logic                         mem_wr_ack
);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BYTE_W = OFF_W - WSEL_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = WORDS * DATA_W;
    localparam int WA_W   = ADDR_W - BYTE_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    sc_state_e         state_q, state_d;
    logic [WA_W-1:0]   lat_waddr_q;
    logic              victim_q;
    logic [WSEL_W-1:0] beat_q;
    logic [LINE_W-1:0] fill_buf_q;
    logic [WA_W-1:0]   use_waddr;
    logic              accept;
    logic              fill_done;
    logic              victim_c;

    assign use_waddr = (state_q == ST_IDLE) ? cpu_addr[ADDR_W-1:BYTE_W] : lat_waddr_q;
    assign cur_wsel  = use_waddr[WSEL_W-1:0];
    assign cur_idx   = use_waddr[WSEL_W +: IDX_W];
    assign cur_tag   = use_waddr[WA_W-1 -: TAG_W];

    assign accept    = (state_q == ST_IDLE) && cpu_req && !snp_conflict;
    assign fill_done = (state_q == ST_FILL) && mem_rd_valid && (beat_q == LAST_BEAT);
    assign victim_c  = !look_vld[0] ? 1'b0 : (!look_vld[1] ? 1'b1 : lru_victim);

    always_comb begin
        fill_line = fill_buf_q;
        fill_line[beat_q*DATA_W +: DATA_W] = mem_rd_data;
    end

    always_comb begin
        cpu_wr_en = (accept && cpu_we) ? look_hit : 2'b00;
        fill_en   = fill_done ? (victim_q ? 2'b10 : 2'b01) : 2'b00;
        lru_we    = (accept && (look_hit != 2'b00)) || fill_done;
        lru_way   = fill_done ? victim_q : look_hit[1];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cpu_we)                  state_d = ST_WRITE;
                    else if (look_hit != 2'b00)  state_d = ST_RESP;
                    else                         state_d = ST_FILL;
                end
            end
            ST_FILL:  if (fill_done)  state_d = ST_RESP;
            ST_WRITE: if (mem_wr_ack) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_ready   <= 1'b0;
            cpu_hit     <= 1'b0;
            cpu_rdata   <= '0;
            lat_waddr_q <= '0;
            victim_q    <= 1'b0;
            beat_q      <= '0;
            fill_buf_q  <= '0;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
            mem_wr_req  <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            cpu_ready <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        lat_waddr_q <= cpu_addr[ADDR_W-1:BYTE_W];
                        cpu_hit     <= (look_hit != 2'b00);
                        if (cpu_we) begin
                            mem_wr_req  <= 1'b1;
                            mem_wr_addr <= cpu_addr;
                            mem_wr_data <= cpu_wdata;
                        end else if (look_hit != 2'b00) begin
                            cpu_ready <= 1'b1;
                            cpu_rdata <= hit_word;
                        end else begin
                            mem_rd_req  <= 1'b1;
                            mem_rd_addr <= {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                            beat_q      <= '0;
                            victim_q    <= victim_c;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        fill_buf_q <= fill_line;
                        beat_q     <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) begin
                            mem_rd_req <= 1'b0;
                            cpu_ready  <= 1'b1;
                            cpu_rdata  <= fill_line[cur_wsel*DATA_W +: DATA_W];
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ack) begin
                        mem_wr_req <= 1'b0;
                        cpu_ready  <= 1'b1;
                    end
                end
                ST_RESP: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R5
    wr_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_we) |=> (mem_wr_req && mem_wr_addr == $past(cpu_addr)
                                && mem_wr_data == $past(cpu_wdata)));

    // R6
    no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (!mem_rd_req && fill_en == 2'b00));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && snp_conflict) |=> (state_q == ST_IDLE && !cpu_ready));
endmodule

// File: rtl/snarf_cache2w.sv
module snarf_cache2w #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 1024,
    parameter int SRC_W      = 2,
    parameter int OWN_SRC    = 0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cpu_req,
    input  logic                                cpu_we,
    input  logic [ADDR_W-1:0]                   cpu_addr,
    input  logic [DATA_W-1:0]                   cpu_wdata,
    output logic                                cpu_ready,
    output logic                                cpu_hit,
    output logic [DATA_W-1:0]                   cpu_rdata,
    output logic                                mem_rd_req,
    output logic [ADDR_W-1:0]                   mem_rd_addr,
    input  logic                                mem_rd_valid,
    input  logic [DATA_W-1:0]                   mem_rd_data,
    output logic                                mem_wr_req,
    output logic [ADDR_W-1:0]                   mem_wr_addr,
    output logic [DATA_W-1:0]                   mem_wr_data,
    input  logic                                mem_wr_ack,
    input  logic                                snp_valid,
    input  logic [SRC_W-1:0]                    snp_src,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]  snp_waddr,
    input  logic [DATA_W-1:0]                   snp_data
);
    localparam int WAYS   = 2;
    localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = WORDS * DATA_W;
    localparam int WA_W   = ADDR_W - $clog2(DATA_W / 8);

    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [WSEL_W-1:0] cur_wsel;
    logic [WAYS-1:0]   look_hit, look_vld, cpu_wr_en, fill_en;
    logic [LINE_W-1:0] look_line [WAYS];
    logic [LINE_W-1:0] fill_line;
    logic [DATA_W-1:0] hit_word;
    logic              lru_victim, lru_we, lru_way;
    logic              snp_active, snp_conflict;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    logic [WSEL_W-1:0] snp_wsel;

    assign snp_active   = snp_valid && (snp_src != SRC_W'(OWN_SRC));
    assign snp_wsel     = snp_waddr[WSEL_W-1:0];
    assign snp_idx      = snp_waddr[WSEL_W +: IDX_W];
    assign snp_tag      = snp_waddr[WA_W-1 -: TAG_W];
    assign snp_conflict = snp_active && (snp_idx == cur_idx);
    assign hit_word     = look_line[look_hit[1]][cur_wsel*DATA_W +: DATA_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        sc_way #(
            .SETS(SETS), .TAG_W(TAG_W), .WORDS(WORDS), .DATA_W(DATA_W)
        ) u_way (
            .clk(clk), .rst_n(rst_n),
            .look_idx(cur_idx), .look_tag(cur_tag),
            .look_hit(look_hit[w]), .look_vld(look_vld[w]), .look_line(look_line[w]),
            .cpu_wr_en(cpu_wr_en[w]), .cpu_wsel(cur_wsel), .cpu_wdata(cpu_wdata),
            .fill_en(fill_en[w]), .fill_line(fill_line),
            .snp_en(snp_active), .snp_idx(snp_idx), .snp_tag(snp_tag),
            .snp_wsel(snp_wsel), .snp_data(snp_data)
        );
    end

    sc_lru #(.SETS(SETS)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(cur_idx), .victim(lru_victim),
        .we(lru_we), .wr_idx(cur_idx), .wr_way(lru_way)
    );

    sc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .cur_idx(cur_idx), .cur_tag(cur_tag), .cur_wsel(cur_wsel),
        .look_hit(look_hit), .look_vld(look_vld), .hit_word(hit_word),
        .lru_victim(lru_victim), .snp_conflict(snp_conflict),
        .cpu_wr_en(cpu_wr_en), .fill_en(fill_en), .fill_line(fill_line),
        .lru_we(lru_we), .lru_way(lru_way),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    // R3
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(look_hit[0] && look_hit[1]));

    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpu_ready && !mem_rd_req && !mem_wr_req));
endmodule

// File: tb/sim_snarf_cache2w.sv
module sim_snarf_cache2w;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_hit;
    logic [31:0] cpu_rdata;
    logic        mem_rd_req, mem_wr_req;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic        mem_rd_valid = 1'b0, mem_wr_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_src = '0;
    logic [29:0] snp_waddr = '0;
    logic [31:0] snp_data = '0;

    always #2 clk = ~clk;

    snarf_cache2w u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
        .snp_valid(snp_valid), .snp_src(snp_src), .snp_waddr(snp_waddr), .snp_data(snp_data)
    );

    int n_chk = 0, n_bad = 0;
    logic [31:0] bmem [256];
    int          bcnt = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
    // residency model for sets 0..7, 2-bit tags
    logic [1:0]  m_tag [8][2];
    logic        m_vld [8][2];
    logic        m_lru [8];

    function automatic logic [31:0] mk(input int tg, input int st, input int wd);
        return {15'd0, tg[1:0], st[9:0], wd[2:0], 2'b00};
    endfunction
    function automatic int bidx(input logic [31:0] a);
        return int'({a[16:15], a[7:5], a[4:2]});
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: one beat per cycle, immediate write acknowledge
    always @(negedge clk) begin
        if (mem_rd_req) begin
            last_rd_addr = mem_rd_addr;
            mem_rd_valid = 1'b1;
            mem_rd_data  = bmem[bidx(mem_rd_addr) + bcnt];
            bcnt++;
        end else begin
            mem_rd_valid = 1'b0;
            bcnt = 0;
        end
        if (mem_wr_req && !mem_wr_ack) begin
            mem_wr_ack = 1'b1;
            last_wr_addr = mem_wr_addr;
            bmem[bidx(mem_wr_addr)] = mem_wr_data;
        end else begin
            mem_wr_ack = 1'b0;
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          input bit sn, input logic [1:0] ssrc, input logic [31:0] sa,
                          input logic [31:0] sd, input string req,
                          input logic [31:0] exp_rd, input bit exp_hit, input int exp_lat);
        int lat = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (sn) begin
            snp_valid = 1'b1; snp_src = ssrc; snp_waddr = sa[31:2]; snp_data = sd;
            if (ssrc != 2'd0) bmem[bidx(sa)] = sd;
        end
        forever begin
            @(posedge clk); #1;
            snp_valid = 1'b0;
            lat++;
            if (cpu_ready || lat > 40) break;
        end
        check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        check(cpu_hit == exp_hit, {req, " hit"}, {31'd0, cpu_hit}, {31'd0, exp_hit});
        if (!we) check(cpu_rdata == exp_rd, {req, " data"}, cpu_rdata, exp_rd);
        @(negedge clk); cpu_req = 1'b0;
        @(posedge clk); #1;
        check(!cpu_ready, "R12 ready pulse", {31'd0, cpu_ready}, 32'd0);
    endtask

    function automatic int m_way(input logic [31:0] a);
        int s = int'(a[7:5]);
        for (int w = 0; w < 2; w++)
            if (m_vld[s][w] && m_tag[s][w] == a[16:15]) return w;
        return -1;
    endfunction

    task automatic rd(input logic [31:0] a, input string req, input int extra = 0,
                      input bit sn = 0, input logic [31:0] sa = 0, input logic [31:0] sd = 0);
        int s = int'(a[7:5]);
        int w;
        logic [31:0] exp_d;
        if (sn) bmem[bidx(sa)] = sd;
        exp_d = bmem[bidx(a)];
        w = m_way(a);
        access(0, a, 0, sn, 2'd1, sa, sd, req, exp_d, w >= 0, (w >= 0 ? 1 : 9) + extra);
        if (w >= 0) begin
            m_lru[s] = ~w[0];
        end else begin
            w = !m_vld[s][0] ? 0 : (!m_vld[s][1] ? 1 : int'(m_lru[s]));
            m_vld[s][w] = 1'b1; m_tag[s][w] = a[16:15]; m_lru[s] = ~w[0];
            check(last_rd_addr == {a[31:5], 5'd0}, "R4 line address", last_rd_addr, {a[31:5], 5'd0});
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string req);
        int w = m_way(a);
        access(1, a, d, 0, 0, 0, 0, req, 0, w >= 0, 2);
        check(last_wr_addr == a, "R5 forwarded address", last_wr_addr, a);
        check(bmem[bidx(a)] == d, "R5 forwarded data", bmem[bidx(a)], d);
        if (w >= 0) m_lru[a[7:5]] = ~w[0];
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 32'hC0DE_0000 + i * 32'h0001_0301;
        for (int s = 0; s < 8; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R2 reset state
        check(!cpu_ready && !mem_rd_req && !mem_wr_req, "R2 reset outputs",
              {29'd0, cpu_ready, mem_rd_req, mem_wr_req}, 32'd0);
        // R1 R3 R4 sweep: every word of sets 0..7, first touch misses
        for (int s = 0; s < 8; s++)
            for (int wd = 0; wd < 8; wd++) rd(mk(1, s, (wd * 3 + s) % 8), "R1/R3/R4 sweep");
        // R7 replacement order in set 2
        rd(mk(2, 2, 4), "R7 second way fill");
        rd(mk(1, 2, 0), "R7 touch way0");
        rd(mk(3, 2, 1), "R7 evict lru");
        rd(mk(1, 2, 7), "R7 keep recent");
        rd(mk(2, 2, 4), "R7 evicted tag misses");
        rd(mk(3, 2, 5), "R7 refill");
        // R5 write hit then read back
        wr(mk(1, 0, 3), 32'hDEAD_BEEF, "R5 write hit");
        rd(mk(1, 0, 3), "R5 read after write hit");
        // R6 write miss, then read misses
        wr(mk(2, 5, 1), 32'h1234_5678, "R6 write miss");
        rd(mk(2, 5, 1), "R6 no allocate");
        // R8 snarf into resident line (other source, not same cycle)
        @(negedge clk);
        snp_valid = 1'b1; snp_src = 2'd2; snp_waddr = mk(1, 4, 6) >> 2; snp_data = 32'hABCD_0004;
        bmem[bidx(mk(1, 4, 6))] = 32'hABCD_0004;
        @(negedge clk); snp_valid = 1'b0;
        rd(mk(1, 4, 6), "R8 snarfed word");
        // R9 snoop to non-resident line
        @(negedge clk);
        snp_valid = 1'b1; snp_src = 2'd3; snp_waddr = mk(3, 6, 0) >> 2; snp_data = 32'h0BAD_0006;
        bmem[bidx(mk(3, 6, 0))] = 32'h0BAD_0006;
        @(negedge clk); snp_valid = 1'b0;
        rd(mk(3, 6, 0), "R9 no allocate on snoop");
        // R10 own-source snoop ignored
        @(negedge clk);
        snp_valid = 1'b1; snp_src = 2'd0; snp_waddr = mk(1, 7, 2) >> 2; snp_data = 32'hFFFF_0007;
        @(negedge clk); snp_valid = 1'b0;
        rd(mk(1, 7, 2), "R10 own snoop ignored");
        // R11 same-set conflict stalls one cycle, snoop data wins
        rd(mk(1, 3, 5), "R11 same set stall", 1, 1, mk(1, 3, 5), 32'h5A5A_0003);
        rd(mk(1, 1, 2), "R11 other set no stall", 0, 1, mk(1, 6, 4), 32'h7777_0006);
        rd(mk(1, 6, 4), "R11 other set snarfed");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule